// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt

This block watches the digital outputs of two analog comparators and flags an interrupt whenever either output differs from the value captured at the most recent access to the status/control register. Each raw comparator output first passes through a two-stage synchronizer. A per-channel polarity invert then applies. The result, called the live output, is compared against a snapshot latch. Software reads the status/control register to see the live outputs. The read also reloads the snapshot, which ends the mismatch so that the flag can then be cleared.

The interrupt flag is a two-state machine. In `FLG_CLEAR` it moves to `FLG_RAISED` on a hardware set (a mismatch with no status access in that cycle) or on a software write of 1. In `FLG_RAISED` it returns to `FLG_CLEAR` only on a software write of 0. While a mismatch persists, a cleared flag is raised again on the next cycle. The interrupt request needs the flag and three enables: a local enable, a peripheral enable and a global enable. Each live output can also be routed to a pin under a per-channel mode bit.

The block is a register-bus slave with single-cycle read and write strobes. Read data is combinational from the address.

Top module: `cmp_change_irq`

## Requirements
- R1: A change of either raw comparator input shows up as a live-output change two clock edges later, and it sets the flag at the following edge.
- R2: The status register (address 0) reports live outputs in bits 7 (channel 1) and 6 (channel 0), invert controls in bits 5:4 and pin-mode bits in bits 3:2. Setting an invert bit flips the reported output of that channel.
- R3: While the live outputs differ from the snapshot, the flag is set every cycle. A write of 0 to the flag clears it for one cycle only, and it is set again at the next edge.
- R4: Any read or write of the status register loads the snapshot from the live outputs. After that, a flag cleared by software stays clear while the inputs hold.
- R5: The flag register (address 1) holds the flag in bit 0, the local enable in bit 1, the peripheral enable in bit 2 and the global enable in bit 3. Writing bit 0 as 1 sets the flag and writing it as 0 clears it.
- R6: `irq` is 1 exactly when the flag and all three enables are 1.
- R7: A mismatch sets the flag even when every enable is 0.
- R8: After reset, both registers read 0, and `irq`, `cmp_pin` and `cmp_pin_oe` are 0.
- R9: When pin-mode bit i is 1, `cmp_pin_oe[i]` is 1 and `cmp_pin[i]` carries live output i. Otherwise both are 0.
- R10: A status-register access in the cycle in which a live output changes takes priority: the snapshot absorbs the change and the flag is not set for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 2 | Raw comparator outputs (asynchronous) |
| bus_addr | input | 1 | Register address: 0 status/control, 1 flag/enables |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| cmp_pin | output | 2 | Live outputs routed to pins |
| cmp_pin_oe | output | 2 | Pin drive enables |

## Verification
The hardest situation to reach is the dropped event of R10. A status read must land in exactly the cycle in which a synchronized output change first becomes visible. The directed stimulus toggles a raw input and lets two edges pass. It then issues the read at the third edge and checks that the flag stays clear both then and one cycle later. Random traffic with sparse accesses and free-running input toggles runs against a cycle-level bench model. This covers the other collisions, such as invert writes that create a mismatch and flag writes during a persistent mismatch.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;
    localparam int NCH    = 2;
    localparam int ADDR_W = 1;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_STAT = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 1'b1;

    // status/control register layout
    localparam int STAT_OUT_LSB = 6;
    localparam int STAT_INV_LSB = 4;
    localparam int STAT_PIN_LSB = 2;

    // flag/enable register layout
    localparam int FLAG_BIT = 0;
    localparam int LEN_BIT  = 1;
    localparam int PEN_BIT  = 2;
    localparam int GEN_BIT  = 3;

    typedef enum logic {
        FLG_CLEAR  = 1'b0,
        FLG_RAISED = 1'b1
    } flag_state_t;
endpackage

// File: rtl/cmpirq_sync.sv
module cmpirq_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= '0;
        end else begin
            chain[0] <= d;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cmpirq_detect.sv
module cmpirq_detect #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] synced,
    input  logic [W-1:0] invert,
    input  logic         load,
    output logic [W-1:0] live,
    output logic [W-1:0] snap,
    output logic         mismatch
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pol
            assign live[i] = synced[i] ^ invert[i];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    snap <= '0;
        else if (load) snap <= live;
    end

    assign mismatch = (live != snap);
endmodule

// File: rtl/cmpirq_flag_fsm.sv
module cmpirq_flag_fsm
    import cmpirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch,
    input  logic suppress,
    input  logic sw_wr,
    input  logic sw_val,
    output logic flag
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: begin
                if (sw_wr) begin
                    if (sw_val) state_d = FLG_RAISED;
                end else if (mismatch && !suppress) begin
                    state_d = FLG_RAISED;
                end
            end
            FLG_RAISED: begin
                if (sw_wr && !sw_val) state_d = FLG_CLEAR;
            end
        endcase
    end

    always_comb begin
        flag = (state_q == FLG_RAISED);
    end
endmodule

// File: rtl/cmp_change_irq.sv
module cmp_change_irq
    import cmpirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    cmp_raw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic [NCH-1:0]    cmp_pin,
    output logic [NCH-1:0]    cmp_pin_oe
);
    logic [NCH-1:0] synced_w, live_w, snap_w;
    logic [NCH-1:0] inv_q, pin_en_q;
    logic           len_q, pen_q, gen_q;
    logic           mismatch_w, flag_q;
    logic           stat_acc, stat_wr, flag_wr;

    assign stat_acc = (bus_rd || bus_wr) && (bus_addr == ADDR_STAT);
    assign stat_wr  = bus_wr && (bus_addr == ADDR_STAT);
    assign flag_wr  = bus_wr && (bus_addr == ADDR_FLAG);

    cmpirq_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cmp_raw),
        .q     (synced_w)
    );

    cmpirq_detect #(.W(NCH)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .synced   (synced_w),
        .invert   (inv_q),
        .load     (stat_acc),
        .live     (live_w),
        .snap     (snap_w),
        .mismatch (mismatch_w)
    );

    cmpirq_flag_fsm u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .mismatch (mismatch_w),
        .suppress (stat_acc),
        .sw_wr    (flag_wr),
        .sw_val   (bus_wdata[FLAG_BIT]),
        .flag     (flag_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_q    <= '0;
            pin_en_q <= '0;
            len_q    <= 1'b0;
            pen_q    <= 1'b0;
            gen_q    <= 1'b0;
        end else begin
            if (stat_wr) begin
                inv_q    <= bus_wdata[STAT_INV_LSB +: NCH];
                pin_en_q <= bus_wdata[STAT_PIN_LSB +: NCH];
            end
            if (flag_wr) begin
                len_q <= bus_wdata[LEN_BIT];
                pen_q <= bus_wdata[PEN_BIT];
                gen_q <= bus_wdata[GEN_BIT];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_STAT: begin
                bus_rdata[STAT_OUT_LSB +: NCH] = live_w;
                bus_rdata[STAT_INV_LSB +: NCH] = inv_q;
                bus_rdata[STAT_PIN_LSB +: NCH] = pin_en_q;
            end
            ADDR_FLAG: begin
                bus_rdata[FLAG_BIT] = flag_q;
                bus_rdata[LEN_BIT]  = len_q;
                bus_rdata[PEN_BIT]  = pen_q;
                bus_rdata[GEN_BIT]  = gen_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign irq = flag_q && len_q && pen_q && gen_q;

    genvar i;
    generate
        for (i = 0; i < NCH; i++) begin : g_pin
            assign cmp_pin[i]    = pin_en_q[i] ? live_w[i] : 1'b0;
            assign cmp_pin_oe[i] = pin_en_q[i];
        end
    endgenerate
endmodule

// File: rtl/cmpirq_checker.sv
module cmpirq_checker
    import cmpirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic              flag,
    input logic              gen,
    input logic [NCH-1:0]    live,
    input logic [NCH-1:0]    snap
);
    logic acc, fwr;
    assign acc = (bus_rd || bus_wr) && (bus_addr == ADDR_STAT);
    assign fwr = bus_wr && (bus_addr == ADDR_FLAG);

    p_mismatch_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((live != snap) && !acc && !fwr) |=> flag);

    p_access_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (snap == $past(live)));

    p_flag_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fwr |=> (flag == $past(bus_wdata[FLAG_BIT])));

    p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && gen));

    p_access_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !flag) |=> !flag);
endmodule

bind cmp_change_irq cmpirq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .flag      (flag_q),
    .gen       (gen_q),
    .live      (live_w),
    .snap      (snap_w)
);

// File: tb/cmp_change_irq_bench.sv
module cmp_change_irq_bench;
    import cmpirq_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [1:0] cmp_raw = '0;
    logic       bus_addr = 1'b0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic [1:0] cmp_pin, cmp_pin_oe;

    int checks = 0, errors = 0;
    bit done = 0;

    cmp_change_irq u_cmp_change_irq (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .cmp_pin(cmp_pin), .cmp_pin_oe(cmp_pin_oe)
    );

    // cycle-level model built from the requirements
    logic [1:0] m_s1, m_s2, m_inv, m_pen, m_snap;
    logic       m_flag, m_le, m_pe, m_ge;

    function automatic logic [1:0] m_live();
        return m_s2 ^ m_inv;
    endfunction

    function automatic logic [7:0] m_rdata(input logic a);
        if (a == 1'b0) return {m_live(), m_inv, m_pen, 2'b00};
        return {4'h0, m_ge, m_pe, m_le, m_flag};
    endfunction

    function automatic logic [1:0] m_pin();
        return m_live() & m_pen;
    endfunction

    always @(posedge clk) begin
        logic [1:0] lv;
        logic acc, mm;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_inv = '0; m_pen = '0; m_snap = '0;
            m_flag = 0; m_le = 0; m_pe = 0; m_ge = 0;
        end else begin
            lv  = m_s2 ^ m_inv;
            acc = (bus_rd || bus_wr) && (bus_addr == 1'b0);
            mm  = (lv != m_snap);
            if (acc) m_snap = lv;
            if (bus_wr && bus_addr == 1'b0) begin
                m_inv = bus_wdata[5:4];
                m_pen = bus_wdata[3:2];
            end
            if (bus_wr && bus_addr == 1'b1) begin
                m_flag = bus_wdata[0]; m_le = bus_wdata[1];
                m_pe = bus_wdata[2];   m_ge = bus_wdata[3];
            end else if (mm && !acc) begin
                m_flag = 1'b1;
            end
            m_s2 = m_s1;
            m_s1 = cmp_raw;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        chk(bus_addr ? "R5 flag reg" : "R2 status reg", bus_rdata, m_rdata(bus_addr));
        chk("R6 irq", {7'b0, irq}, {7'b0, m_flag & m_le & m_pe & m_ge});
        chk("R9 pins", {4'b0, cmp_pin_oe, cmp_pin}, {4'b0, m_pen, m_pin()});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic idle();
        bus_rd = 0; bus_wr = 0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
        step();
        idle();
    endtask

    task automatic peek(input logic a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5EED_C0DE));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8: reset state
        peek(1'b0, v); chk("R8 status", v, 8'h00);
        peek(1'b1, v); chk("R8 flag", v, 8'h00);
        chk("R8 outputs", {3'b0, irq, cmp_pin_oe, cmp_pin}, 8'h00);

        // R1 / R7: change sets the flag with enables off
        cmp_raw = 2'b01;
        step(); step();
        peek(1'b1, v); chk("R1 not yet", {7'b0, v[0]}, 8'h00);
        step();
        peek(1'b1, v); chk("R1 flag set", {7'b0, v[0]}, 8'h01);
        chk("R7 flag without enables", v, 8'h01);
        chk("R7 no irq", {7'b0, irq}, 8'h00);

        // R3: clear during persistent mismatch comes back
        wr(1'b1, 8'h00);
        peek(1'b1, v); chk("R3 cleared one cycle", {7'b0, v[0]}, 8'h00);
        step();
        peek(1'b1, v); chk("R3 set again", {7'b0, v[0]}, 8'h01);

        // R4: read ends mismatch, then the clear sticks
        bus_addr = 1'b0; bus_rd = 1;
        #1 chk("R2 live bit6", bus_rdata, 8'h40);
        step(); idle();
        wr(1'b1, 8'h00);
        step(); step();
        peek(1'b1, v); chk("R4 clear sticks", {7'b0, v[0]}, 8'h00);

        // R2: invert flips the reported outputs
        wr(1'b0, 8'h30);
        peek(1'b0, v); chk("R2 inverted", v, 8'hB0);
        bus_rd = 1; step(); idle();
        wr(1'b1, 8'h00);
        step();

        // R5 / R6: software set and enable gating
        wr(1'b1, 8'h0F); chk("R5 sw set irq", {7'b0, irq}, 8'h01);
        wr(1'b1, 8'h07); chk("R6 no global", {7'b0, irq}, 8'h00);
        wr(1'b1, 8'h0B); chk("R6 no peripheral", {7'b0, irq}, 8'h00);
        wr(1'b1, 8'h0D); chk("R6 no local", {7'b0, irq}, 8'h00);
        wr(1'b1, 8'h0E); chk("R5 sw clear", {7'b0, irq}, 8'h00);
        step();
        peek(1'b1, v); chk("R5 stays clear", v, 8'h0E);

        // R10: access coincident with the change drops the event
        cmp_raw = 2'b10;
        step(); step();
        bus_addr = 1'b0; bus_rd = 1;
        step(); idle();
        peek(1'b1, v); chk("R10 dropped", {7'b0, v[0]}, 8'h00);
        step();
        peek(1'b1, v); chk("R10 still clear", {7'b0, v[0]}, 8'h00);

        // R9: pin routing
        wr(1'b0, 8'h3C);
        chk("R9 both on", {4'b0, cmp_pin_oe, cmp_pin}, {4'b0, 2'b11, m_live()});
        wr(1'b0, 8'h34);
        chk("R9 ch0 only", {4'b0, cmp_pin_oe, cmp_pin}, {4'b0, 2'b01, 1'b0, m_live()[0]});

        // random phase against the model
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 15);
            bus_rd = (r == 0); bus_wr = (r == 1) || (r == 2);
            bus_addr = 1'($urandom_range(0, 1));
            bus_wdata = 8'($urandom);
            if ($urandom_range(0, 5) == 0) cmp_raw = 2'($urandom);
            step();
        end
        idle();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule